// File: doc/BRIEF.md
# Per-Pin Peripheral Function Multiplexer

This block sits between a bank of I/O pads and the logic that wants to drive them. Every pin belongs either to the general-purpose I/O logic or to one of four peripheral functions, called A, B, C and D. For each pin, the block routes the output value and the output enable from the current owner to the pad. The pad's input value goes to every peripheral and to a data-status register.

Software changes ownership with masked strobes. It writes a mask to a strobe address and only the pins whose mask bit is 1 change. Two per-pin select vectors choose the peripheral. The block has dedicated pick strobes that change both select bits of the masked pins in one write, and it also accepts whole-vector writes of each select vector. A build parameter gives a legacy variant that has only peripherals A and B. In that variant a single select bit per pin is driven by an A strobe and a B strobe.

Reads are registered: data returns one cycle after the read strobe, together with a valid flag.

Top module: `pfmux_bank`

## Requirements
- R1: After reset, every pin is owned by the I/O logic with its output disabled. The output data, sel1 and sel2 all read zero, so pad_oe is 0 on every pin.
- R2: A write to address 0 sets ownership to I/O for each masked pin. A write to address 1 hands each masked pin to its peripheral. Unmasked pins keep their ownership.
- R3: A write to address 6 gives the masked pins to the I/O logic and clears their output enable in the same cycle.
- R4: Reading address 0 returns 1 for each I/O-owned pin. An I/O-owned pin drives pad_out from its data bit and pad_oe from its enable bit, whatever its select bits hold.
- R5: A peripheral-owned pin uses the code {sel2,sel1}. The codes are 00 for A, 01 for B, 10 for C and 11 for D. The pin drives pad_out and pad_oe from the chosen peripheral's out and oe ports.
- R6: In four-way mode (FOUR_WAY=1), writes to addresses 7, 8, 9 and 10 load codes 00, 01, 10 and 11 into the masked pins only. Writes to addresses 11 and 12 load the whole sel1 and sel2 vectors.
- R7: In legacy mode (FOUR_WAY=0), address 7 clears sel1 of the masked pins and address 8 sets it. Addresses 9, 10 and 12 have no effect, and sel2 always reads 0. Peripheral-owned pins therefore choose A or B only.
- R8: Addresses 2 and 3 set and clear the I/O output-enable bits of the masked pins. Addresses 4 and 5 set and clear the I/O output-data bits of the masked pins.
- R9: periph_in follows pad_in with no delay. Reading address 3 returns pad_in as it was sampled one clock earlier.
- R10: A read strobe returns rd_data with rd_valid one cycle later. The read addresses are 0 for ownership, 1 for output enable, 2 for output data, 3 for pad input, 4 for sel1 and 5 for sel2. Any other read address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 32 | Write data or pin mask |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 32 | Read data, one cycle after rd_en |
| rd_valid | output | 1 | rd_data is valid |
| pa_out | input | 32 | Peripheral A output values |
| pa_oe | input | 32 | Peripheral A output enables |
| pb_out | input | 32 | Peripheral B output values |
| pb_oe | input | 32 | Peripheral B output enables |
| pc_out | input | 32 | Peripheral C output values |
| pc_oe | input | 32 | Peripheral C output enables |
| pd_out | input | 32 | Peripheral D output values |
| pd_oe | input | 32 | Peripheral D output enables |
| periph_in | output | 32 | Pad input broadcast to the peripherals |
| pad_in | input | 32 | Pad input values |
| pad_out | output | 32 | Pad output values |
| pad_oe | output | 32 | Pad output enables |

## Verification
The hardest case to reach is a pin whose select bits point to one peripheral while the pin is owned by the I/O logic, or a pin whose codes differ between the two variants. The stimulus sets up mixed select codes with both the pick strobes and the whole-vector writes. It then hands a few of those pins back to the I/O logic and checks that the select bits no longer matter. A four-way instance and a legacy instance share one write bus, so the same C, D and sel2 writes show their effect in one variant and no effect in the other. Each peripheral drives distinct patterns, so a wrong routing choice shows up on the pads.

// File: rtl/pfmux_pkg.sv
// Package: shared address codes and the peripheral function type for the
// pin function multiplexer. Assumes a 4-bit word address for both ports.
package pfmux_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        W_GPIO_TAKE   = 4'd0,
        W_PERIPH_TAKE = 4'd1,
        W_OE_SET      = 4'd2,
        W_OE_CLR      = 4'd3,
        W_DAT_SET     = 4'd4,
        W_DAT_CLR     = 4'd5,
        W_GPIO_IN     = 4'd6,
        W_PICK_A      = 4'd7,
        W_PICK_B      = 4'd8,
        W_PICK_C      = 4'd9,
        W_PICK_D      = 4'd10,
        W_SEL1        = 4'd11,
        W_SEL2        = 4'd12
    } wr_reg_e;

    typedef enum logic [ADDR_W-1:0] {
        R_OWNER = 4'd0,
        R_OE    = 4'd1,
        R_DATA  = 4'd2,
        R_PADIN = 4'd3,
        R_SEL1  = 4'd4,
        R_SEL2  = 4'd5
    } rd_reg_e;

    localparam int NFUNC = 4;
    typedef enum logic [1:0] {FN_A = 2'd0, FN_B = 2'd1, FN_C = 2'd2, FN_D = 2'd3} periph_e;
endpackage

// File: rtl/pfmux_ctl_regs.sv
// Module: ownership, I/O output and select registers updated by masked strobes.
// Assumes one write per cycle; wr_data is the pin mask for strobe addresses.
// FOUR_WAY=0 builds the legacy A/B variant with sel2 held at zero.
module pfmux_ctl_regs
    import pfmux_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter bit FOUR_WAY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    output logic [NPINS-1:0]  owner,
    output logic [NPINS-1:0]  gpio_oe,
    output logic [NPINS-1:0]  gpio_dat,
    output logic [NPINS-1:0]  sel1,
    output logic [NPINS-1:0]  sel2
);
    logic [NPINS-1:0] own_n, oe_n, dat_n;
    wr_reg_e          waddr;

    assign waddr = wr_reg_e'(wr_addr);

    // Next ownership, output enable and data from the masked strobes
    always_comb begin
        own_n = owner;
        oe_n  = gpio_oe;
        dat_n = gpio_dat;
        if (wr_en) begin
            case (waddr)
                W_GPIO_TAKE:   own_n = owner | wr_data;
                W_PERIPH_TAKE: own_n = owner & ~wr_data;
                W_GPIO_IN: begin
                    own_n = owner | wr_data;
                    oe_n  = gpio_oe & ~wr_data;
                end
                W_OE_SET:  oe_n  = gpio_oe | wr_data;
                W_OE_CLR:  oe_n  = gpio_oe & ~wr_data;
                W_DAT_SET: dat_n = gpio_dat | wr_data;
                W_DAT_CLR: dat_n = gpio_dat & ~wr_data;
                default: ;
            endcase
        end
    end

    // Ownership and I/O output state registers, reset to I/O inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner    <= '1;
            gpio_oe  <= '0;
            gpio_dat <= '0;
        end else begin
            owner    <= own_n;
            gpio_oe  <= oe_n;
            gpio_dat <= dat_n;
        end
    end

    generate
        if (FOUR_WAY) begin : g_four
            logic [NPINS-1:0] s1_n, s2_n;

            // Next select vectors: pick strobes touch masked pins, direct writes load all
            always_comb begin
                s1_n = sel1;
                s2_n = sel2;
                if (wr_en) begin
                    case (waddr)
                        W_PICK_A: begin s1_n = sel1 & ~wr_data; s2_n = sel2 & ~wr_data; end
                        W_PICK_B: begin s1_n = sel1 |  wr_data; s2_n = sel2 & ~wr_data; end
                        W_PICK_C: begin s1_n = sel1 & ~wr_data; s2_n = sel2 |  wr_data; end
                        W_PICK_D: begin s1_n = sel1 |  wr_data; s2_n = sel2 |  wr_data; end
                        W_SEL1:   s1_n = wr_data;
                        W_SEL2:   s2_n = wr_data;
                        default: ;
                    endcase
                end
            end

            // Select registers for the four-way variant
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    sel1 <= '0;
                    sel2 <= '0;
                end else begin
                    sel1 <= s1_n;
                    sel2 <= s2_n;
                end
            end

            // R6
            pick_d_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && waddr == W_PICK_D) |=>
                    (((sel1 & sel2) & $past(wr_data)) == $past(wr_data)));
        end else begin : g_legacy
            logic [NPINS-1:0] s1_n;

            // Next single select bit: A clears, B sets, direct write loads all
            always_comb begin
                s1_n = sel1;
                if (wr_en) begin
                    case (waddr)
                        W_PICK_A: s1_n = sel1 & ~wr_data;
                        W_PICK_B: s1_n = sel1 |  wr_data;
                        W_SEL1:   s1_n = wr_data;
                        default: ;
                    endcase
                end
            end

            // Select register for the legacy variant; sel2 does not exist
            always_ff @(posedge clk) begin
                if (!rst_n) sel1 <= '0;
                else        sel1 <= s1_n;
            end
            assign sel2 = '0;

            // R7
            legacy_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && (waddr == W_PICK_C || waddr == W_PICK_D)) |=> $stable(sel1));
        end
    endgenerate

    // R2
    take_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == W_GPIO_TAKE) |=> ((owner & $past(wr_data)) == $past(wr_data)));

    // R2
    take_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (waddr == W_GPIO_TAKE || waddr == W_PERIPH_TAKE)) |=>
            ((owner & ~$past(wr_data)) == ($past(owner) & ~$past(wr_data))));

    // R3
    gpio_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == W_GPIO_IN) |=> ((gpio_oe & $past(wr_data)) == '0));

    // R6
    sel_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr >= W_PICK_A && waddr <= W_PICK_D) |=>
            (((sel1 & ~$past(wr_data)) == ($past(sel1) & ~$past(wr_data))) &&
             ((sel2 & ~$past(wr_data)) == ($past(sel2) & ~$past(wr_data)))));
endmodule

// File: rtl/pfmux_route.sv
// Module: per-pin routing of output value and enable from the owner to the pad.
// Assumes per_out/per_oe are indexed by the peripheral code {sel2,sel1}.
module pfmux_route
    import pfmux_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic [NPINS-1:0]            owner,
    input  logic [NPINS-1:0]            sel1,
    input  logic [NPINS-1:0]            sel2,
    input  logic [NPINS-1:0]            gpio_dat,
    input  logic [NPINS-1:0]            gpio_oe,
    input  logic [NFUNC-1:0][NPINS-1:0] per_out,
    input  logic [NFUNC-1:0][NPINS-1:0] per_oe,
    output logic [NPINS-1:0]            pad_out,
    output logic [NPINS-1:0]            pad_oe
);
    generate
        for (genvar i = 0; i < NPINS; i++) begin : g_pin
            periph_e fn;
            // Peripheral code of this pin
            assign fn = periph_e'({sel2[i], sel1[i]});
            // Pad drive: I/O state when owned by I/O, else the chosen peripheral
            assign pad_out[i] = owner[i] ? gpio_dat[i] : per_out[fn][i];
            assign pad_oe[i]  = owner[i] ? gpio_oe[i]  : per_oe[fn][i];
        end
    endgenerate
endmodule

// File: rtl/pfmux_readback.sv
// Module: samples the pad inputs and returns a registered read of the state.
// Assumes one read per cycle; unknown addresses read zero.
module pfmux_readback
    import pfmux_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [NPINS-1:0]  owner,
    input  logic [NPINS-1:0]  gpio_oe,
    input  logic [NPINS-1:0]  gpio_dat,
    input  logic [NPINS-1:0]  sel1,
    input  logic [NPINS-1:0]  sel2,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  rd_data,
    output logic              rd_valid
);
    logic [NPINS-1:0] pad_smp;
    logic [NPINS-1:0] rd_mux;

    // Pad input sample register feeding the data-status read
    always_ff @(posedge clk) begin
        if (!rst_n) pad_smp <= '0;
        else        pad_smp <= pad_in;
    end

    // Read address decode
    always_comb begin
        case (rd_reg_e'(rd_addr))
            R_OWNER: rd_mux = owner;
            R_OE:    rd_mux = gpio_oe;
            R_DATA:  rd_mux = gpio_dat;
            R_PADIN: rd_mux = pad_smp;
            R_SEL1:  rd_mux = sel1;
            R_SEL2:  rd_mux = sel2;
            default: rd_mux = '0;
        endcase
    end

    // Registered read data and valid flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= rd_mux;
        end
    end

    // R10
    rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    // R10
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);
endmodule

// File: rtl/pfmux_bank.sv
// Module: top of the pin function multiplexer for one bank of pins.
// Assumes all inputs are synchronous to clk except pad_in, which is only
// sampled for readback. FOUR_WAY selects the A-D or the legacy A/B variant.
module pfmux_bank
    import pfmux_pkg::*;
#(
    parameter int NPINS    = 32,
    parameter bit FOUR_WAY = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [3:0]        wr_addr,
    input  logic [NPINS-1:0]  wr_data,
    input  logic              rd_en,
    input  logic [3:0]        rd_addr,
    output logic [NPINS-1:0]  rd_data,
    output logic              rd_valid,
    input  logic [NPINS-1:0]  pa_out,
    input  logic [NPINS-1:0]  pa_oe,
    input  logic [NPINS-1:0]  pb_out,
    input  logic [NPINS-1:0]  pb_oe,
    input  logic [NPINS-1:0]  pc_out,
    input  logic [NPINS-1:0]  pc_oe,
    input  logic [NPINS-1:0]  pd_out,
    input  logic [NPINS-1:0]  pd_oe,
    output logic [NPINS-1:0]  periph_in,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe
);
    logic [NPINS-1:0]            owner, gpio_oe, gpio_dat, sel1, sel2;
    logic [NFUNC-1:0][NPINS-1:0] per_out, per_oe;

    // Peripheral sources packed by function code
    assign per_out = {pd_out, pc_out, pb_out, pa_out};
    assign per_oe  = {pd_oe,  pc_oe,  pb_oe,  pa_oe};
    // Pad input goes to every peripheral unchanged
    assign periph_in = pad_in;

    pfmux_ctl_regs #(.NPINS(NPINS), .FOUR_WAY(FOUR_WAY)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .owner(owner), .gpio_oe(gpio_oe), .gpio_dat(gpio_dat), .sel1(sel1), .sel2(sel2)
    );

    pfmux_route #(.NPINS(NPINS)) u_route (
        .owner(owner), .sel1(sel1), .sel2(sel2), .gpio_dat(gpio_dat), .gpio_oe(gpio_oe),
        .per_out(per_out), .per_oe(per_oe), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    pfmux_readback #(.NPINS(NPINS)) u_rdbk (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .owner(owner), .gpio_oe(gpio_oe), .gpio_dat(gpio_dat), .sel1(sel1), .sel2(sel2),
        .pad_in(pad_in), .rd_data(rd_data), .rd_valid(rd_valid)
    );
endmodule

// File: tb/sim_pfmux_bank.sv
// Bench: a four-way instance (u0) and a legacy instance (u1) share one bus.
// Reads push expected words into per-instance queues; a monitor pops and compares.
module sim_pfmux_bank;
    localparam int N = 32;

    logic clk = 1'b0, rst_n = 1'b0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] wr_addr = '0, rd_addr = '0;
    logic [N-1:0] wr_data = '0, pad_in = '0;
    logic [N-1:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe, pd_out, pd_oe;
    logic [N-1:0] rd_data0, rd_data1, pin0, pin1, po0, po1, poe0, poe1;
    logic rv0, rv1;

    int checks = 0, errors = 0;
    logic [N-1:0] q0[$], q1[$];
    string qtag0[$], qtag1[$];
    logic [N-1:0] m_own[2], m_oe[2], m_dat[2], m_s1[2], m_s2[2];

    always #5 clk = ~clk;

    pfmux_bank #(.NPINS(N), .FOUR_WAY(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data0), .rd_valid(rv0),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_out(pc_out), .pc_oe(pc_oe), .pd_out(pd_out), .pd_oe(pd_oe),
        .periph_in(pin0), .pad_in(pad_in), .pad_out(po0), .pad_oe(poe0));

    pfmux_bank #(.NPINS(N), .FOUR_WAY(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data1), .rd_valid(rv1),
        .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_out(pc_out), .pc_oe(pc_oe), .pd_out(pd_out), .pd_oe(pd_oe),
        .periph_in(pin1), .pad_in(pad_in), .pad_out(po1), .pad_oe(poe1));

    task automatic check(string tag, logic [N-1:0] act, logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Reference model of the register effects, from the requirements
    task automatic model_write(logic [3:0] a, logic [N-1:0] d);
        for (int k = 0; k < 2; k++) begin
            case (a)
                4'd0: m_own[k] |= d;
                4'd1: m_own[k] &= ~d;
                4'd2: m_oe[k]  |= d;
                4'd3: m_oe[k]  &= ~d;
                4'd4: m_dat[k] |= d;
                4'd5: m_dat[k] &= ~d;
                4'd6: begin m_own[k] |= d; m_oe[k] &= ~d; end
                4'd7: begin m_s1[k] &= ~d; m_s2[k] &= ~d; end
                4'd8: begin m_s1[k] |= d;  m_s2[k] &= ~d; end
                4'd9: if (k == 0) begin m_s1[k] &= ~d; m_s2[k] |= d; end
                4'd10: if (k == 0) begin m_s1[k] |= d; m_s2[k] |= d; end
                4'd11: m_s1[k] = d;
                4'd12: if (k == 0) m_s2[k] = d;
                default: ;
            endcase
        end
    endtask

    function automatic logic [N-1:0] model_read(int k, logic [3:0] a);
        case (a)
            4'd0: return m_own[k];
            4'd1: return m_oe[k];
            4'd2: return m_dat[k];
            4'd3: return pad_in;
            4'd4: return m_s1[k];
            4'd5: return m_s2[k];
            default: return '0;
        endcase
    endfunction

    task automatic wr(logic [3:0] a, logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        model_write(a, d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Driver: issue a read and queue the expected word for both instances
    task automatic rd(string tag, logic [3:0] a);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        q0.push_back(model_read(0, a)); qtag0.push_back({tag, " u0"});
        q1.push_back(model_read(1, a)); qtag1.push_back({tag, " u1"});
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    // Compare both instances' pads with the model (R4, R5, R7)
    task automatic check_pads(string tag);
        for (int k = 0; k < 2; k++) begin
            logic [N-1:0] eo, ee;
            for (int i = 0; i < N; i++) begin
                logic [1:0] fn;
                fn = {m_s2[k][i], m_s1[k][i]};
                if (m_own[k][i]) begin eo[i] = m_dat[k][i]; ee[i] = m_oe[k][i]; end
                else case (fn)
                    2'd0: begin eo[i] = pa_out[i]; ee[i] = pa_oe[i]; end
                    2'd1: begin eo[i] = pb_out[i]; ee[i] = pb_oe[i]; end
                    2'd2: begin eo[i] = pc_out[i]; ee[i] = pc_oe[i]; end
                    default: begin eo[i] = pd_out[i]; ee[i] = pd_oe[i]; end
                endcase
            end
            check({tag, (k == 0) ? " u0 pad_out" : " u1 pad_out"}, (k == 0) ? po0 : po1, eo);
            check({tag, (k == 0) ? " u0 pad_oe" : " u1 pad_oe"}, (k == 0) ? poe0 : poe1, ee);
        end
    endtask

    // Monitor: pop and compare as read data appears
    always begin
        @(posedge clk);
        #1;
        if (rv0) begin
            if (q0.size() == 0) check("R10 unexpected u0 valid", 1, 0);
            else check(qtag0.pop_front(), rd_data0, q0.pop_front());
        end
        if (rv1) begin
            if (q1.size() == 0) check("R10 unexpected u1 valid", 1, 0);
            else check(qtag1.pop_front(), rd_data1, q1.pop_front());
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        pa_out = 32'h1111_AAAA; pa_oe = 32'hFFFF_0000;
        pb_out = 32'h2222_5555; pb_oe = 32'h0F0F_F0F0;
        pc_out = 32'h4444_CCCC; pc_oe = 32'h00FF_FF00;
        pd_out = 32'h8888_3333; pd_oe = 32'hF00F_0FF0;
        for (int k = 0; k < 2; k++) begin
            m_own[k] = '1; m_oe[k] = '0; m_dat[k] = '0; m_s1[k] = '0; m_s2[k] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check_pads("R1 reset");
        check("R1 reset pad_oe u0", poe0, '0);
        for (int a = 0; a < 6; a++) rd("R1 reset read", 4'(a));
        // R8 I/O output enable and data strobes
        wr(4'd2, 32'h0000_FFFF);
        wr(4'd4, 32'h00FF_00FF);
        wr(4'd5, 32'h0000_00F0);
        wr(4'd3, 32'h0000_0F00);
        check_pads("R8 io drive");
        rd("R8 oe read", 4'd1);
        rd("R8 data read", 4'd2);
        // R2 hand upper pins to peripherals (code 00 = A)
        wr(4'd1, 32'hFFFF_0000);
        check_pads("R2 R5 periph A");
        rd("R2 owner read", 4'd0);
        // R5 R6 R7 pick strobes
        wr(4'd8, 32'h00F0_0000);
        check_pads("R5 pick B");
        wr(4'd9, 32'h0F00_0000);
        check_pads("R6 R7 pick C");
        wr(4'd10, 32'hF000_0000);
        check_pads("R6 R7 pick D");
        rd("R6 R7 sel1 read", 4'd4);
        rd("R6 R7 sel2 read", 4'd5);
        // R7 legacy A strobe clears sel1 of masked pins only
        wr(4'd7, 32'h0030_0000);
        check_pads("R7 pick A");
        rd("R7 sel1 after A", 4'd4);
        // R6 R7 whole-vector select writes
        wr(4'd11, 32'h1234_5678);
        wr(4'd12, 32'h9ABC_DEF0);
        check_pads("R6 R7 direct sel");
        rd("R6 sel1 direct", 4'd4);
        rd("R7 sel2 direct", 4'd5);
        // R4 I/O ownership overrides select bits
        wr(4'd0, 32'h3000_0000);
        check_pads("R4 io override");
        rd("R4 owner read", 4'd0);
        // R3 give to I/O as input
        wr(4'd2, 32'hFFFF_FFFF);
        wr(4'd1, 32'h0000_FF00);
        wr(4'd6, 32'h0000_0F00);
        check_pads("R3 gpio input");
        rd("R3 oe read", 4'd1);
        rd("R3 owner read", 4'd0);
        // R5 new peripheral patterns
        pa_out = ~pa_out; pb_oe = ~pb_oe; pc_out = 32'h0F1E_2D3C; pd_oe = 32'hFFFF_FFFF;
        #1;
        check_pads("R5 new patterns");
        // R9 pad input broadcast and sampled readback
        @(negedge clk);
        pad_in = 32'hC0DE_F00D;
        #1;
        check("R9 periph_in u0", pin0, 32'hC0DE_F00D);
        check("R9 periph_in u1", pin1, 32'hC0DE_F00D);
        repeat (2) @(negedge clk);
        rd("R9 pad read", 4'd3);
        pad_in = 32'h1357_9BDF;
        repeat (2) @(negedge clk);
        rd("R9 pad read 2", 4'd3);
        // R10 unknown address reads zero
        rd("R10 unused addr", 4'd14);
        repeat (4) @(negedge clk);
        check("R10 queue drained", 32'(q0.size() + q1.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule